// File: doc/BRIEF.md
# Bridge Fault and Enable Supervisor

This block sits between the fault detectors of a two-bridge stepper driver and the gate drive of its output bridges. It turns an active-low output enable, an active-low sleep control, three chip-wide fault flags and per-bridge overcurrent flags into one enable per bridge, a reset that returns the step translator to its Home state, and a fault status vector. All inputs are asynchronous and pass through a two-flop synchronizer first.

Faults fall into two classes. Live faults stop every bridge only while the flag is present: overtemperature, undervoltage on the gate supply and a regulator fault. Per-bridge overcurrent also has two kinds. A short to ground latches the affected bridge off until the sleep control is released. A short across the load starts a fixed off-time of `OFF_CYCLES` clocks, after which the bridge is re-enabled. If the short persists, this repeats. The enable and sleep controls gate the outputs only. They do not hold the translator reset, the off-time timers or the latches.

Each bridge has a state machine with three states. BR_RUN means the bridge may drive. BR_CHOP means an off-time is running. BR_LATCH means the bridge is locked off by a short to ground. The transitions are:
- run_to_latch and chop_to_latch on a ground short.
- run_to_chop on a load short.
- chop_to_run when the off-time expires.
- latch_to_run on a rising edge of the sleep control.

A second state machine drives the translator reset. It has the states HM_HOLD (undervoltage present or just after reset), HM_COUNT (counting out the hold time) and HM_READY. Its transitions are:
- hold_to_count when undervoltage clears.
- count_to_hold and ready_to_hold when undervoltage returns.
- count_to_ready when the count expires.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: While the synchronized enable input is high or the synchronized sleep input is low, every bit of `bridge_en` is 0.
- R2: The enable input changes neither the timing of `home_rst` nor the progress of off-time timers and short-to-ground latches.
- R3: A synchronized overtemperature or regulator-fault flag forces every bridge off only while it is present. Once it clears, the bridges return in the next cycle.
- R4: Synchronized undervoltage forces every bridge off, and no bridge is enabled while `home_rst` is high.
- R5: `home_rst` is high from reset and while synchronized undervoltage is present. It stays high for `HOME_HOLD`+1 further cycles after synchronized undervoltage clears, so a drop of `uv_flag` is followed by `home_rst` falling on the `HOME_HOLD`+3rd clock edge.
- R6: A synchronized short-to-ground flag on bridge i turns off bridge i only and keeps it off after the flag clears. Other bridges are unaffected.
- R7: A short-to-ground latch clears only on a rising edge of the synchronized sleep input (or on reset). The bridge is enabled one cycle after the synchronized sleep input rises, if nothing else blocks it.
- R8: A synchronized shorted-load flag on bridge i turns bridge i off for exactly `OFF_CYCLES` cycles and then re-enables it. A flag that persists restarts the off-time each time the bridge returns to run.
- R9: Every input passes two synchronizer flops. A change in enable, sleep or a live fault reaches `bridge_en` on the second clock edge, and a change in an overcurrent flag reaches it on the third.
- R10: `fault_status` packs the following fields:
  - bit 0: synchronized undervoltage.
  - bit 1: synchronized overtemperature.
  - bit 2: synchronized regulator fault.
  - bits 3 to 3+N-1: short-to-ground latch per bridge.
  - bits 3+N to 3+2N-1: off-time running per bridge.
- R11: During reset `bridge_en` is 0, `home_rst` is 1 and `fault_status` shows only undervoltage (value 1). The synchronizer holds enable high and undervoltage asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en_n | input | 1 | Active-low output enable |
| sleep_n | input | 1 | Active-low sleep; a rising edge clears ground-short latches |
| uv_flag | input | 1 | Gate-supply undervoltage, active high |
| ot_flag | input | 1 | Overtemperature, active high |
| reg_fault | input | 1 | Regulator supply fault, active high |
| short_gnd | input | NUM_BRIDGES | Per-bridge short-to-ground overcurrent |
| short_load | input | NUM_BRIDGES | Per-bridge shorted-load overcurrent |
| bridge_en | output | NUM_BRIDGES | Per-bridge output enable |
| home_rst | output | 1 | Translator Home reset |
| fault_status | output | 3+2*NUM_BRIDGES | Live and latched fault vector |

## Verification
Results arrive at a fixed latency after each input edge:
- Enable, sleep and live-fault changes appear at the outputs after two clock edges.
- Overcurrent flags and the sleep rising edge take effect after three edges.
- `home_rst` falls `HOME_HOLD`+3 edges after undervoltage drops.

The bench drives its inputs on falling edges and keeps its own two-stage copy of the synchronizer. A behavioural reference advances on each rising edge, and the design is compared with it on every falling edge. Directed checks count edges from the driving falling edge and sample at the exact falling edge where each output is due to change, as well as one edge before it.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    // Bit positions inside the synchronized input vector
    localparam int IDX_EN    = 0;
    localparam int IDX_SLEEP = 1;
    localparam int IDX_UV    = 2;
    localparam int IDX_OT    = 3;
    localparam int IDX_REG   = 4;
    localparam int IDX_STG0  = 5;

    function automatic int in_width(input int nb);
        return IDX_STG0 + 2 * nb;
    endfunction

    function automatic int stat_width(input int nb);
        return 3 + 2 * nb;
    endfunction

    typedef enum logic [1:0] {
        BR_RUN   = 2'd0,
        BR_CHOP  = 2'd1,
        BR_LATCH = 2'd2
    } bridge_state_e;

    typedef enum logic [1:0] {
        HM_HOLD  = 2'd0,
        HM_COUNT = 2'd1,
        HM_READY = 2'd2
    } home_state_e;

endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe_q[s] <= RST_VAL;
            end
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/bfs_bridge_fsm.sv
module bfs_bridge_fsm
    import bfs_pkg::*;
#(
    parameter int OFF_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnd_short,
    input  logic load_short,
    input  logic sleep_rise,
    output logic may_run,
    output logic chopping,
    output logic latched
);

    localparam int CW = (OFF_CYCLES < 2) ? 1 : $clog2(OFF_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(OFF_CYCLES - 1);

    bridge_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BR_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BR_RUN: begin
                if (gnd_short) begin
                    state_d = BR_LATCH;              // run_to_latch
                end else if (load_short) begin
                    state_d = BR_CHOP;               // run_to_chop
                    cnt_d   = LOAD_VAL;
                end
            end
            BR_CHOP: begin
                if (gnd_short) begin
                    state_d = BR_LATCH;              // chop_to_latch
                end else if (cnt_q == '0) begin
                    state_d = BR_RUN;                // chop_to_run
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            BR_LATCH: begin
                if (sleep_rise) begin
                    state_d = BR_RUN;                // latch_to_run
                end
            end
            default: begin
                state_d = BR_LATCH;
            end
        endcase
    end

    // Outputs
    always_comb begin
        may_run  = 1'b0;
        chopping = 1'b0;
        latched  = 1'b0;
        unique case (state_q)
            BR_RUN:   may_run  = 1'b1;
            BR_CHOP:  chopping = 1'b1;
            BR_LATCH: latched  = 1'b1;
            default:  latched  = 1'b1;
        endcase
    end

endmodule

// File: rtl/bfs_home_fsm.sv
module bfs_home_fsm
    import bfs_pkg::*;
#(
    parameter int HOLD_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic undervolt,
    output logic home_busy
);

    localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    home_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HM_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HM_HOLD: begin
                if (!undervolt) begin
                    state_d = HM_COUNT;              // hold_to_count
                    cnt_d   = LOAD_VAL;
                end
            end
            HM_COUNT: begin
                if (undervolt) begin
                    state_d = HM_HOLD;               // count_to_hold
                end else if (cnt_q == '0) begin
                    state_d = HM_READY;              // count_to_ready
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            HM_READY: begin
                if (undervolt) begin
                    state_d = HM_HOLD;               // ready_to_hold
                end
            end
            default: begin
                state_d = HM_HOLD;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            HM_READY: home_busy = 1'b0;
            default:  home_busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor
    import bfs_pkg::*;
#(
    parameter int NUM_BRIDGES = 2,
    parameter int OFF_CYCLES  = 8,
    parameter int HOME_HOLD   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_n,
    input  logic                         sleep_n,
    input  logic                         uv_flag,
    input  logic                         ot_flag,
    input  logic                         reg_fault,
    input  logic [NUM_BRIDGES-1:0]       short_gnd,
    input  logic [NUM_BRIDGES-1:0]       short_load,
    output logic [NUM_BRIDGES-1:0]       bridge_en,
    output logic                         home_rst,
    output logic [3+2*NUM_BRIDGES-1:0]   fault_status
);

    localparam int VW = in_width(NUM_BRIDGES);
    localparam int SW = stat_width(NUM_BRIDGES);

    // Reset view: outputs disabled and undervoltage assumed present
    localparam logic [VW-1:0] SYNC_RST =
        (VW'(1) << IDX_EN) | (VW'(1) << IDX_UV);

    logic [VW-1:0]          raw_v;
    logic [VW-1:0]          sync_v;
    logic                   en_s, sleep_s, uv_s, ot_s, reg_s;
    logic [NUM_BRIDGES-1:0] stg_s, sld_s;
    logic                   sleep_prev_q;
    logic                   sleep_rise;
    logic [NUM_BRIDGES-1:0] run_v, chop_v, latch_v;
    logic                   home_busy;
    logic                   live_ok;

    assign raw_v = {short_load, short_gnd, reg_fault, ot_flag, uv_flag, sleep_n, en_n};

    bfs_sync #(
        .W       (VW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (sync_v)
    );

    assign en_s    = sync_v[IDX_EN];
    assign sleep_s = sync_v[IDX_SLEEP];
    assign uv_s    = sync_v[IDX_UV];
    assign ot_s    = sync_v[IDX_OT];
    assign reg_s   = sync_v[IDX_REG];
    assign stg_s   = sync_v[IDX_STG0 +: NUM_BRIDGES];
    assign sld_s   = sync_v[IDX_STG0 + NUM_BRIDGES +: NUM_BRIDGES];

    // Sleep release edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_prev_q <= 1'b0;
        end else begin
            sleep_prev_q <= sleep_s;
        end
    end

    assign sleep_rise = sleep_s & ~sleep_prev_q;

    // One guard per bridge
    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
        bfs_bridge_fsm #(
            .OFF_CYCLES (OFF_CYCLES)
        ) u_guard (
            .clk        (clk),
            .rst_n      (rst_n),
            .gnd_short  (stg_s[b]),
            .load_short (sld_s[b]),
            .sleep_rise (sleep_rise),
            .may_run    (run_v[b]),
            .chopping   (chop_v[b]),
            .latched    (latch_v[b])
        );
    end

    bfs_home_fsm #(
        .HOLD_CYCLES (HOME_HOLD)
    ) u_home (
        .clk       (clk),
        .rst_n     (rst_n),
        .undervolt (uv_s),
        .home_busy (home_busy)
    );

    // Output gating
    always_comb begin
        live_ok      = ~en_s & sleep_s & ~uv_s & ~ot_s & ~reg_s & ~home_busy;
        bridge_en    = run_v & {NUM_BRIDGES{live_ok}};
        home_rst     = home_busy;
        fault_status = SW'({chop_v, latch_v, reg_s, ot_s, uv_s});
    end

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_s,
    input logic          sleep_s,
    input logic          uv_s,
    input logic          ot_s,
    input logic          reg_s,
    input logic          sleep_rise,
    input logic          home_rst,
    input logic [NB-1:0] stg_s,
    input logic [NB-1:0] chop_v,
    input logic [NB-1:0] latch_v,
    input logic [NB-1:0] bridge_en
);

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s || !sleep_s) |-> (bridge_en == '0)); // R1

    AST_LIVE_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_s || reg_s || uv_s) |-> (bridge_en == '0)); // R3

    AST_HOME_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        home_rst |-> (bridge_en == '0)); // R4

    AST_HOME_UNDER_UV: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> home_rst); // R5

    for (genvar b = 0; b < NB; b++) begin : g_chk
        AST_SHORT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            (stg_s[b] && !(latch_v[b] && sleep_rise)) |=> latch_v[b]); // R6

        AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_v[b] && !sleep_rise) |=> (latch_v[b] && !bridge_en[b])); // R7

        AST_CHOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            chop_v[b] |-> (!bridge_en[b] && !latch_v[b])); // R8
    end

endmodule

bind bridge_fault_supervisor bfs_checker #(
    .NB (NUM_BRIDGES)
) u_bfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_s       (en_s),
    .sleep_s    (sleep_s),
    .uv_s       (uv_s),
    .ot_s       (ot_s),
    .reg_s      (reg_s),
    .sleep_rise (sleep_rise),
    .home_rst   (home_rst),
    .stg_s      (stg_s),
    .chop_v     (chop_v),
    .latch_v    (latch_v),
    .bridge_en  (bridge_en)
);

// File: tb/bridge_fault_supervisor_bench.sv
`timescale 1ns/1ps
module bridge_fault_supervisor_bench;

    localparam int NB   = 2;
    localparam int OFF  = 8;
    localparam int HOLD = 12;
    localparam int VW   = 5 + 2 * NB;
    localparam int SW   = 3 + 2 * NB;
    localparam logic [VW-1:0] RSTV = VW'(5'b00101);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1, sleep_n = 1'b0, uv_flag = 1'b1, ot_flag = 1'b0, reg_fault = 1'b0;
    logic [NB-1:0] short_gnd = '0, short_load = '0;
    logic [NB-1:0] bridge_en;
    logic          home_rst;
    logic [SW-1:0] fault_status;

    always #10 clk = ~clk;

    bridge_fault_supervisor #(
        .NUM_BRIDGES (NB),
        .OFF_CYCLES  (OFF),
        .HOME_HOLD   (HOLD),
        .SYNC_STAGES (2)
    ) u_bridge_fault_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_n         (en_n),
        .sleep_n      (sleep_n),
        .uv_flag      (uv_flag),
        .ot_flag      (ot_flag),
        .reg_fault    (reg_fault),
        .short_gnd    (short_gnd),
        .short_load   (short_load),
        .bridge_en    (bridge_en),
        .home_rst     (home_rst),
        .fault_status (fault_status)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R11";
    bit    done     = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [VW-1:0] raw;
    logic [VW-1:0] m_s1, m_s2;
    logic          m_sprev;
    int            m_mode [NB];   // 0 run, 1 off-time, 2 latched
    int            m_tmr  [NB];
    int            m_quiet;

    assign raw = {short_load, short_gnd, reg_fault, ot_flag, uv_flag, sleep_n, en_n};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = RSTV; m_s2 = RSTV; m_sprev = 1'b0; m_quiet = 0;
            for (int i = 0; i < NB; i++) begin m_mode[i] = 0; m_tmr[i] = 0; end
        end else begin
            logic rise;
            rise = m_s2[1] && !m_sprev;
            for (int i = 0; i < NB; i++) begin
                logic g, l;
                g = m_s2[5 + i];
                l = m_s2[5 + NB + i];
                if (m_mode[i] == 0) begin
                    if (g) m_mode[i] = 2;
                    else if (l) begin m_mode[i] = 1; m_tmr[i] = OFF - 1; end
                end else if (m_mode[i] == 1) begin
                    if (g) m_mode[i] = 2;
                    else if (m_tmr[i] == 0) m_mode[i] = 0;
                    else m_tmr[i] = m_tmr[i] - 1;
                end else begin
                    if (rise) m_mode[i] = 0;
                end
            end
            if (m_s2[2]) m_quiet = 0;
            else if (m_quiet <= HOLD) m_quiet = m_quiet + 1;
            m_sprev = m_s2[1];
            m_s2 = m_s1;
            m_s1 = raw;
        end
    end

    function automatic logic [NB-1:0] exp_en();
        logic ok;
        logic [NB-1:0] r;
        ok = !m_s2[0] && m_s2[1] && !m_s2[2] && !m_s2[3] && !m_s2[4] && (m_quiet > HOLD);
        for (int i = 0; i < NB; i++) r[i] = ok && (m_mode[i] == 0);
        return r;
    endfunction

    function automatic logic [SW-1:0] exp_stat();
        logic [NB-1:0] lt, ch;
        for (int i = 0; i < NB; i++) begin
            lt[i] = (m_mode[i] == 2);
            ch[i] = (m_mode[i] == 1);
        end
        return {ch, lt, m_s2[4], m_s2[3], m_s2[2]};
    endfunction

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " bridge_en"}, 32'(bridge_en), 32'(exp_en()));
            chk({cur_req, " home_rst"}, 32'(home_rst), 32'(m_quiet <= HOLD));
            chk({cur_req, " fault_status R10"}, 32'(fault_status), 32'(exp_stat()));
        end
    end

    task automatic nedge(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        nedge(2);
        // R11 reset state
        chk("R11 bridge_en", 32'(bridge_en), 0);
        chk("R11 home_rst", 32'(home_rst), 1);
        chk("R11 fault_status", 32'(fault_status), 1);
        rst_n = 1'b1;
        nedge(3);

        // R5: release undervoltage, home reset falls on edge HOLD+3
        cur_req = "R5";
        uv_flag = 1'b0; sleep_n = 1'b1; en_n = 1'b0;
        nedge(HOLD + 2);
        chk("R5 home_rst still high", 32'(home_rst), 1);
        chk("R4 bridges off during home", 32'(bridge_en), 0);
        nedge(1);
        chk("R5 home_rst released", 32'(home_rst), 0);
        chk("R4 bridges on after home", 32'(bridge_en), 3);
        nedge(3);

        // R1 / R9: enable gating with two-edge latency
        cur_req = "R1";
        en_n = 1'b1;
        nedge(1);
        chk("R9 enable not yet seen", 32'(bridge_en), 3);
        nedge(1);
        chk("R1 enable high turns off", 32'(bridge_en), 0);
        en_n = 1'b0;
        nedge(4);
        chk("R1 enable low restores", 32'(bridge_en), 3);
        sleep_n = 1'b0;
        nedge(2);
        chk("R1 sleep low turns off", 32'(bridge_en), 0);
        sleep_n = 1'b1;
        nedge(4);

        // R3: live faults
        cur_req = "R3";
        ot_flag = 1'b1;
        nedge(2);
        chk("R3 overtemp off", 32'(bridge_en), 0);
        chk("R10 overtemp bit", 32'(fault_status), 32'h2);
        nedge(3);
        ot_flag = 1'b0;
        nedge(2);
        chk("R3 overtemp cleared", 32'(bridge_en), 3);
        reg_fault = 1'b1;
        nedge(2);
        chk("R3 regulator off", 32'(bridge_en), 0);
        chk("R10 regulator bit", 32'(fault_status), 32'h4);
        reg_fault = 1'b0;
        nedge(2);
        chk("R3 regulator cleared", 32'(bridge_en), 3);

        // R4: undervoltage pulse re-runs the home hold
        cur_req = "R4";
        uv_flag = 1'b1;
        nedge(2);
        chk("R4 undervoltage off", 32'(bridge_en), 0);
        nedge(1);
        chk("R5 home_rst under uv", 32'(home_rst), 1);
        uv_flag = 1'b0;
        nedge(HOLD + 4);
        chk("R4 back after home", 32'(bridge_en), 3);

        // R2: enable off does not slow the home hold or the off-time
        cur_req = "R2";
        en_n = 1'b1; uv_flag = 1'b1;
        nedge(4);
        uv_flag = 1'b0;
        nedge(HOLD + 2);
        chk("R2 home high with enable off", 32'(home_rst), 1);
        nedge(1);
        chk("R2 home released with enable off", 32'(home_rst), 0);
        short_load = 2'b01;
        nedge(1);
        short_load = 2'b00;
        nedge(2);
        chk("R2 off-time runs with enable off", 32'(fault_status), 32'h20);
        nedge(OFF);
        chk("R2 off-time ended with enable off", 32'(fault_status), 32'h0);
        en_n = 1'b0;
        nedge(3);

        // R6: ground short on bridge 0 latches
        cur_req = "R6";
        short_gnd = 2'b01;
        nedge(2);
        chk("R9 short not yet applied", 32'(bridge_en), 3);
        nedge(1);
        chk("R6 bridge 0 off, bridge 1 on", 32'(bridge_en), 2);
        short_gnd = 2'b00;
        nedge(10);
        chk("R6 stays latched", 32'(bridge_en), 2);
        chk("R10 latch bit", 32'(fault_status), 32'h8);

        // R7: enable toggle does not clear; sleep release does
        cur_req = "R7";
        en_n = 1'b1;
        nedge(3);
        en_n = 1'b0;
        nedge(4);
        chk("R7 enable toggle keeps latch", 32'(bridge_en), 2);
        sleep_n = 1'b0;
        nedge(4);
        sleep_n = 1'b1;
        nedge(2);
        chk("R7 latched one cycle after sleep rise", 32'(bridge_en), 2);
        nedge(1);
        chk("R7 cleared by sleep rise", 32'(bridge_en), 3);
        nedge(2);

        // R8: shorted-load pulse on bridge 1
        cur_req = "R8";
        short_load = 2'b10;
        nedge(1);
        short_load = 2'b00;
        cnt = 0;
        for (int k = 0; k < OFF + 6; k++) begin
            nedge(1);
            if (bridge_en[1] == 1'b0) cnt++;
        end
        chk("R8 off exactly OFF cycles", 32'(cnt), 32'(OFF));
        chk("R8 bridge 0 unaffected", 32'(bridge_en), 3);
        // persistent load short repeats off-time
        short_load = 2'b10;
        nedge(4 * (OFF + 1));
        short_load = 2'b00;
        nedge(OFF + 4);
        chk("R8 recovers after persistent short", 32'(bridge_en), 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule